// File: doc/BRIEF.md
# DMA Channel Transfer Counter

This block is the counting engine of one DMA channel. Software programs a 24-bit starting word count, a starting address, the address direction, the transfer mode and whether the channel re-arms itself. A device then raises an asynchronous request. Once the request has been synchronised, the channel grants the bus with an acknowledge. Each completed transfer decrements the word count by one and moves the address by one word.

The terminal-count line works in one of two directions. In output mode the channel drives it during the last transfer, the one that takes the count from zero to all ones. In input mode a device drives it to stop the transfer early. Both cases end the channel's ownership. With auto-initialise on, the channel restores the programmed count and address and can be granted again at once. With auto-initialise off, a done flag is set and holds off further grants.

Demand mode keeps the acknowledge asserted across transfers until the request drops, the transfer ends, or a pending preempt has lasted a fixed number of clocks. Single mode gives up the acknowledge after every transfer.

Top module: `xfer_chan`

## Requirements
- R1: A pulse on `cfgLoad` while `dackOut` is low copies `cfgCount` and `cfgAddr` into the current and base registers, latches the mode bits and clears `doneFlag`; all of this is visible one cycle later. A pulse on `cfgLoad` while `dackOut` is high has no effect.
- R2: `dreqAsync` passes through two synchronising flops. A request that rises before clock edge 1 makes `dackOut` rise at edge 3, provided the channel is idle and `doneFlag` is low.
- R3: Each `xferDone` pulse during a grant decrements `curCount` by one. It also changes `curAddr` by one: upward when the loaded `cfgDown` was 0, downward when it was 1.
- R4: In single mode (`cfgDemand`=0), `dackOut` falls at the edge that takes in a transfer. In demand mode (`cfgDemand`=1), `dackOut` stays high across transfers.
- R5: In either mode, `dackOut` falls at the edge where the synchronised request is seen low, which is the third edge after `dreqAsync` falls.
- R6: In output mode (`cfgTcInput`=0), `tcOe` equals `dackOut`, and `tcOut` is high only while `dackOut` is high and `curCount` is zero. In input mode, `tcOe` and `tcOut` stay low.
- R7: A transfer taken in while `curCount` is zero wraps the count to 24'hFFFFFF and ends the grant. Without auto-initialise it also sets `doneFlag`.
- R8: While `doneFlag` is high, no grant is issued. `doneClr` or a new load clears the flag, after which a held request is granted.
- R9: With auto-initialise (`cfgAutoInit`=1), a terminating event reloads `curCount` and `curAddr` from the programmed base values, ends the grant and leaves `doneFlag` low.
- R10: In input mode, `tcIn` high during a grant ends the transfer without stepping the count. In demand mode `tcIn` is sampled on every edge. In single mode it is sampled only while `cmdActive` is high and is ignored otherwise.
- R11: While granted, a `preemptReq` held for `PREEMPT_CYC` consecutive edges (default 33) makes `dackOut` fall at the last of those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Program strobe, honoured only while idle |
| cfgCount | input | 24 | Starting word count |
| cfgAddr | input | 24 | Starting address |
| cfgDown | input | 1 | 1 = address decrements |
| cfgDemand | input | 1 | 1 = demand mode, 0 = single mode |
| cfgAutoInit | input | 1 | 1 = reload base values on termination |
| cfgTcInput | input | 1 | 1 = terminal-count line is an input |
| doneClr | input | 1 | Clears the done flag |
| dreqAsync | input | 1 | Asynchronous transfer request |
| preemptReq | input | 1 | Another agent wants the bus |
| xferDone | input | 1 | One transfer completed this cycle |
| cmdActive | input | 1 | I/O read or write command active |
| tcIn | input | 1 | External stop, used in input mode |
| dackOut | output | 1 | Channel acknowledge (grant) |
| tcOut | output | 1 | Terminal-count drive value |
| tcOe | output | 1 | Terminal-count output enable |
| doneFlag | output | 1 | Termination latched, grants blocked |
| curCount | output | 24 | Current word count |
| curAddr | output | 24 | Current address |

## Verification
The bench steps a count through zero into the wrap. A design that signalled termination on reaching zero would drop the grant one transfer early. A design that wrapped without latching done would re-grant at once. The bench measures the synchroniser latency and the preempt window to the exact edge, so an extra flop or an off-by-one counter shows up as the acknowledge moving by a cycle. The stop input is driven in single mode without a command, where a design that failed to gate it would terminate early. The bench also attempts a load during a grant, which must leave the count untouched.

// File: rtl/xfer_chan_pkg.sv
package xfer_chan_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic reload;
  } dpStrobe_t;

  typedef enum logic {CH_IDLE = 1'b0, CH_OWN = 1'b1} chanState_t;
endpackage

// File: rtl/xfer_chan_dp.sv
module xfer_chan_dp
  import xfer_chan_pkg::*;
#(
  parameter int COUNT_W = 24,
  parameter int ADDR_W  = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [COUNT_W-1:0] cfgCount,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic               cfgDown,
  output logic               countZero,
  output logic [COUNT_W-1:0] curCount,
  output logic [ADDR_W-1:0]  curAddr
);
  localparam logic [COUNT_W-1:0] CNT_ONE  = COUNT_W'(1);
  localparam logic [ADDR_W-1:0]  ADDR_ONE = ADDR_W'(1);

  logic [COUNT_W-1:0] baseCount;
  logic [ADDR_W-1:0]  baseAddr;
  logic               dirDown;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCount <= '0;
      baseAddr  <= '0;
      dirDown   <= 1'b0;
      curCount  <= '0;
      curAddr   <= '0;
    end else if (strobe.load) begin
      baseCount <= cfgCount;
      baseAddr  <= cfgAddr;
      dirDown   <= cfgDown;
      curCount  <= cfgCount;
      curAddr   <= cfgAddr;
    end else if (strobe.reload) begin
      curCount <= baseCount;
      curAddr  <= baseAddr;
    end else if (strobe.step) begin
      curCount <= curCount - CNT_ONE;
      curAddr  <= dirDown ? curAddr - ADDR_ONE : curAddr + ADDR_ONE;
    end
  end

  assign countZero = (curCount == '0);
endmodule

// File: rtl/xfer_chan_ctrl.sv
module xfer_chan_ctrl
  import xfer_chan_pkg::*;
#(
  parameter int PREEMPT_CYC = 33,
  parameter int SYNC_DEPTH  = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgLoad,
  input  logic      cfgDemand,
  input  logic      cfgAutoInit,
  input  logic      cfgTcInput,
  input  logic      doneClr,
  input  logic      dreqAsync,
  input  logic      preemptReq,
  input  logic      xferDone,
  input  logic      cmdActive,
  input  logic      tcIn,
  input  logic      countZero,
  output dpStrobe_t strobe,
  output logic      dackOut,
  output logic      tcOut,
  output logic      tcOe,
  output logic      doneFlag
);
  localparam int PC_W = $clog2(PREEMPT_CYC + 1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PREEMPT_CYC - 1);

  chanState_t            state;
  logic [SYNC_DEPTH-1:0] syncQ;
  logic                  reqSync;
  logic [PC_W-1:0]       preCnt;
  logic                  modeDemand, modeAuto, modeTcIn;
  logic                  inOwn, grantNow, wrapEv, stopEv, termEv, preemptHit, releaseEv;

  generate
    if (SYNC_DEPTH == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= dreqAsync;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_DEPTH-2:0], dreqAsync};
      end
    end
  endgenerate
  assign reqSync = syncQ[SYNC_DEPTH-1];

  always_comb begin
    inOwn      = (state == CH_OWN);
    grantNow   = !inOwn && reqSync && !doneFlag && !cfgLoad;
    wrapEv     = inOwn && xferDone && countZero;
    stopEv     = inOwn && modeTcIn && tcIn && (modeDemand || cmdActive);
    termEv     = wrapEv || stopEv;
    preemptHit = inOwn && preemptReq && (preCnt == PC_LAST);
    releaseEv  = inOwn && (termEv || preemptHit || !reqSync ||
                           (!modeDemand && xferDone));
    strobe.load   = cfgLoad && !inOwn;
    strobe.reload = termEv && modeAuto;
    strobe.step   = inOwn && xferDone && !(termEv && modeAuto);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= CH_IDLE;
      doneFlag   <= 1'b0;
      preCnt     <= '0;
      modeDemand <= 1'b0;
      modeAuto   <= 1'b0;
      modeTcIn   <= 1'b0;
    end else begin
      if (strobe.load) begin
        modeDemand <= cfgDemand;
        modeAuto   <= cfgAutoInit;
        modeTcIn   <= cfgTcInput;
      end
      if (inOwn) state <= releaseEv ? CH_IDLE : CH_OWN;
      else       state <= grantNow ? CH_OWN : CH_IDLE;
      if (termEv && !modeAuto)        doneFlag <= 1'b1;
      else if (strobe.load || doneClr) doneFlag <= 1'b0;
      if (inOwn && preemptReq && !releaseEv) preCnt <= preCnt + 1'b1;
      else                                    preCnt <= '0;
    end
  end

  assign dackOut = inOwn;
  assign tcOe    = inOwn && !modeTcIn;
  assign tcOut   = tcOe && countZero;
endmodule

// File: rtl/xfer_chan.sv
module xfer_chan
  import xfer_chan_pkg::*;
#(
  parameter int COUNT_W     = 24,
  parameter int ADDR_W      = 24,
  parameter int PREEMPT_CYC = 33
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgLoad,
  input  logic [COUNT_W-1:0] cfgCount,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic               cfgDown,
  input  logic               cfgDemand,
  input  logic               cfgAutoInit,
  input  logic               cfgTcInput,
  input  logic               doneClr,
  input  logic               dreqAsync,
  input  logic               preemptReq,
  input  logic               xferDone,
  input  logic               cmdActive,
  input  logic               tcIn,
  output logic               dackOut,
  output logic               tcOut,
  output logic               tcOe,
  output logic               doneFlag,
  output logic [COUNT_W-1:0] curCount,
  output logic [ADDR_W-1:0]  curAddr
);
  dpStrobe_t strobe;
  logic      countZero;

  xfer_chan_ctrl #(.PREEMPT_CYC(PREEMPT_CYC), .SYNC_DEPTH(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgDemand(cfgDemand),
    .cfgAutoInit(cfgAutoInit), .cfgTcInput(cfgTcInput), .doneClr(doneClr),
    .dreqAsync(dreqAsync), .preemptReq(preemptReq), .xferDone(xferDone),
    .cmdActive(cmdActive), .tcIn(tcIn), .countZero(countZero),
    .strobe(strobe), .dackOut(dackOut), .tcOut(tcOut), .tcOe(tcOe),
    .doneFlag(doneFlag)
  );

  xfer_chan_dp #(.COUNT_W(COUNT_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgCount(cfgCount),
    .cfgAddr(cfgAddr), .cfgDown(cfgDown), .countZero(countZero),
    .curCount(curCount), .curAddr(curAddr)
  );
endmodule

// File: rtl/xfer_chan_chk.sv
module xfer_chan_chk #(
  parameter int COUNT_W = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgLoad,
  input logic               dreqAsync,
  input logic               xferDone,
  input logic               tcIn,
  input logic               dackOut,
  input logic               tcOut,
  input logic               tcOe,
  input logic               doneFlag,
  input logic [COUNT_W-1:0] curCount
);
  // R6: terminal count is only ever driven under the acknowledge
  a_r6_tc_under_ack: assert property (@(posedge clk) disable iff (!rstN)
    (tcOut || tcOe) |-> dackOut);

  // R8: a latched done flag never coexists with a grant
  a_r8_done_no_grant: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> !dackOut);

  // R7: a transfer taken in at zero count ends the grant
  a_r7_wrap_releases: assert property (@(posedge clk) disable iff (!rstN)
    (dackOut && xferDone && curCount == '0) |=> !dackOut);

  // R2: a grant rises only for a request seen two edges earlier
  a_r2_sync_latency: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dackOut) |-> $past(dreqAsync, 2));

  // R1 / R3: the count moves only on a transfer, load or stop input
  a_r3_count_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!xferDone && !cfgLoad && !tcIn) |=> $stable(curCount));
endmodule

bind xfer_chan xfer_chan_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .dreqAsync(dreqAsync),
  .xferDone(xferDone), .tcIn(tcIn), .dackOut(dackOut), .tcOut(tcOut),
  .tcOe(tcOe), .doneFlag(doneFlag), .curCount(curCount)
);

// File: tb/test_xfer_chan.sv
module test_xfer_chan;
  localparam int CW = 24;
  localparam int AW = 24;
  localparam int PC = 33;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 0, cfgDown = 0, cfgDemand = 0, cfgAutoInit = 0, cfgTcInput = 0;
  logic [CW-1:0] cfgCount = '0;
  logic [AW-1:0] cfgAddr = '0;
  logic doneClr = 0, dreqAsync = 0, preemptReq = 0, xferDone = 0, cmdActive = 0, tcIn = 0;
  logic dackOut, tcOut, tcOe, doneFlag;
  logic [CW-1:0] curCount;
  logic [AW-1:0] curAddr;

  int nVec = 0;
  int nBad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xfer_chan #(.COUNT_W(CW), .ADDR_W(AW), .PREEMPT_CYC(PC)) i_xfer_chan (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgCount(cfgCount),
    .cfgAddr(cfgAddr), .cfgDown(cfgDown), .cfgDemand(cfgDemand),
    .cfgAutoInit(cfgAutoInit), .cfgTcInput(cfgTcInput), .doneClr(doneClr),
    .dreqAsync(dreqAsync), .preemptReq(preemptReq), .xferDone(xferDone),
    .cmdActive(cmdActive), .tcIn(tcIn), .dackOut(dackOut), .tcOut(tcOut),
    .tcOe(tcOe), .doneFlag(doneFlag), .curCount(curCount), .curAddr(curAddr)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doLoad(input logic [CW-1:0] c, input logic [AW-1:0] a,
                        input logic dn, input logic dm, input logic au, input logic ti);
    cfgCount = c; cfgAddr = a; cfgDown = dn; cfgDemand = dm;
    cfgAutoInit = au; cfgTcInput = ti; cfgLoad = 1'b1;
    tick();
    cfgLoad = 1'b0;
  endtask

  task automatic xfer();
    xferDone = 1'b1;
    tick();
    xferDone = 1'b0;
  endtask

  task automatic waitGrant(input string req);
    for (int i = 0; i < 8 && !dackOut; i++) tick();
    chk(req, dackOut, 1'b1);
  endtask

  task automatic quiesce();
    dreqAsync = 1'b0;
    repeat (6) tick();
  endtask

  task automatic t_reset();
    chk("R1 reset dack", dackOut, 0);
    chk("R8 reset done", doneFlag, 0);
    chk("R6 reset tcOe", tcOe, 0);
    chk("R1 reset count", curCount, 0);
  endtask

  task automatic t_single();
    doLoad(24'd3, 24'h100, 0, 0, 0, 0);
    chk("R1 load count", curCount, 3);
    chk("R1 load addr", curAddr, 24'h100);
    dreqAsync = 1'b1;
    tick(); chk("R2 edge1 no grant", dackOut, 0);
    tick(); chk("R2 edge2 no grant", dackOut, 0);
    tick(); chk("R2 edge3 grant", dackOut, 1);
    chk("R6 tcOe in output mode", tcOe, 1);
    chk("R6 tcOut low at nonzero", tcOut, 0);
    xfer();
    chk("R3 count step", curCount, 2);
    chk("R3 addr up", curAddr, 24'h101);
    chk("R4 single releases", dackOut, 0);
    waitGrant("R2 regrant");
    xfer();
    waitGrant("R2 regrant");
    xfer();
    chk("R3 count zero", curCount, 0);
    chk("R6 tcOut needs ack", tcOut, 0);
    waitGrant("R2 regrant");
    chk("R6 tcOut at zero", tcOut, 1);
    xfer();
    chk("R7 wrap count", curCount, 24'hFFFFFF);
    chk("R7 addr after four", curAddr, 24'h104);
    chk("R7 release", dackOut, 0);
    chk("R7 done set", doneFlag, 1);
    repeat (5) tick();
    chk("R8 done blocks grant", dackOut, 0);
    doneClr = 1'b1; tick(); doneClr = 1'b0;
    chk("R8 done cleared", doneFlag, 0);
    waitGrant("R8 grant after clear");
    xfer();
    chk("R3 count after wrap", curCount, 24'hFFFFFE);
    quiesce();
  endtask

  task automatic t_auto();
    doLoad(24'd1, 24'h200, 1, 1, 1, 0);
    dreqAsync = 1'b1;
    waitGrant("R2 demand grant");
    doLoad(24'd7, 24'h55, 0, 0, 0, 1);
    chk("R1 load ignored in grant", curCount, 1);
    chk("R1 addr kept in grant", curAddr, 24'h200);
    chk("R1 mode kept in grant", tcOe, 1);
    xfer();
    chk("R3 addr down", curAddr, 24'h1FF);
    chk("R4 demand keeps grant", dackOut, 1);
    chk("R6 tcOut at zero", tcOut, 1);
    xfer();
    chk("R9 reload count", curCount, 1);
    chk("R9 reload addr", curAddr, 24'h200);
    chk("R9 no done", doneFlag, 0);
    chk("R9 release", dackOut, 0);
    waitGrant("R9 regrant");
    dreqAsync = 1'b0;
    tick(); chk("R5 still granted", dackOut, 1);
    tick(); chk("R5 still granted", dackOut, 1);
    tick(); chk("R5 released", dackOut, 0);
    quiesce();
  endtask

  task automatic t_stop();
    doLoad(24'd5, 24'h300, 0, 1, 0, 1);
    dreqAsync = 1'b1;
    waitGrant("R10 grant");
    chk("R6 input mode no drive", tcOe, 0);
    tcIn = 1'b1; tick(); tcIn = 1'b0;
    chk("R10 demand stop release", dackOut, 0);
    chk("R10 demand stop done", doneFlag, 1);
    chk("R10 count not stepped", curCount, 5);
    quiesce();
    doLoad(24'd5, 24'h300, 0, 0, 0, 1);
    chk("R8 load clears done", doneFlag, 0);
    dreqAsync = 1'b1;
    waitGrant("R10 single grant");
    tcIn = 1'b1; tick();
    chk("R10 ignored without cmd", dackOut, 1);
    chk("R10 no done without cmd", doneFlag, 0);
    cmdActive = 1'b1; tick(); tcIn = 1'b0; cmdActive = 1'b0;
    chk("R10 single stop release", dackOut, 0);
    chk("R10 single stop done", doneFlag, 1);
    quiesce();
  endtask

  task automatic t_preempt();
    doLoad(24'd9, 24'h400, 0, 1, 0, 0);
    dreqAsync = 1'b1;
    waitGrant("R11 grant");
    preemptReq = 1'b1;
    repeat (PC - 1) tick();
    chk("R11 held before window", dackOut, 1);
    tick();
    chk("R11 released at window", dackOut, 0);
    preemptReq = 1'b0;
    quiesce();
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_single();
    t_auto();
    t_stop();
    t_preempt();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nVec++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule